// File: doc/BRIEF.md
# Bus Response Timeout Monitor

This block sits beside the core's internal bus port and guarantees that every tracked transfer terminates. A transfer opens when the core raises its read or write strobe. It closes when the target raises acknowledge or error. If the target stays silent for the whole response window, the monitor issues a one-cycle error pulse toward the core. The core then takes a fault instead of stalling forever.

Each strobe carries two tags. The first marks an access to the external memory port; such an access is never tracked. The second says whether the instruction fetch path or the load/store path issued the access. Every error on a tracked transfer, forced or from the target, is routed by that tag to one of two fault pulses. Two sticky status bits record whether the most recent fault was a timeout or a target error. A status read strobe clears them.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset, every output is 0.
- R2: A tracked transfer starting in cycle t0 that sees neither acknowledge nor error in cycles t0 to t0+WINDOW (default 15) gets `core_err_o` high for exactly cycle t0+WINDOW+1.
- R3: An acknowledge or error in any cycle from t0 (same-cycle completion) through t0+WINDOW ends the transfer, and no forced error follows.
- R4: A strobe with `bus_ext_i`=1 is not tracked. It produces no forced error, fault pulse or status change, even if an error response comes back.
- R5: A tracked strobe that arrives while a transfer is still open restarts the window from that strobe, and takes that strobe's source tag.
- R6: An acknowledge or error with no open transfer and no strobe in the same cycle has no effect on any output.
- R7: Each fault is routed by the source tag (1 = instruction fetch, 0 = load/store). A target error in cycle c pulses `fault_fetch_o` or `fault_ldst_o` in cycle c+1. A timeout pulses the matching fault output in the same cycle as `core_err_o`. At most one fault output is high at a time.
- R8: `stat_timeout_o` sets together with `core_err_o`, and `stat_tgterr_o` sets in the cycle after a tracked target error. Setting either bit clears the other.
- R9: `stat_rd_i` high in cycle c clears both status bits from cycle c+1, unless a fault sets a bit in the same cycle c. In that case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd_i | input | 1 | Read strobe from the core |
| bus_wr_i | input | 1 | Write strobe from the core |
| bus_ext_i | input | 1 | Access goes to the external memory port (untracked) |
| bus_fetch_i | input | 1 | Source tag: 1 = instruction fetch, 0 = load/store |
| bus_ack_i | input | 1 | Target acknowledge |
| bus_err_i | input | 1 | Target error |
| stat_rd_i | input | 1 | Status read strobe, clears the sticky bits |
| core_err_o | output | 1 | Forced error response to the core |
| fault_fetch_o | output | 1 | Instruction fetch fault pulse |
| fault_ldst_o | output | 1 | Load/store fault pulse |
| stat_timeout_o | output | 1 | Sticky: last fault was a timeout |
| stat_tgterr_o | output | 1 | Sticky: last fault was a target error |

## Verification
A status read can land in the same cycle as the event that sets a status bit. The bench raises the read in the cycle a target error arrives, and also in the last cycle of the window, when the timeout is decided. In both cases it expects the new bit to survive. A later read in the same transfer must clear the bit. A response on the last allowed cycle of the window against the expiry decision is swept too: a response at delay WINDOW must suppress the forced error, and one at WINDOW+1 must come too late.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

    typedef enum logic {
        ACC_DATA  = 1'b0,
        ACC_FETCH = 1'b1
    } acc_kind_e;

    typedef struct packed {
        logic      hit;
        acc_kind_e kind;
    } fault_ev_t;

    function automatic int cnt_width(input int window);
        return (window < 2) ? 1 : $clog2(window);
    endfunction

endpackage

// File: rtl/busmon_window.sv
module busmon_window
    import busmon_pkg::*;
#(
    parameter int WINDOW = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o,
    output logic expire_o
);
    localparam int CW = cnt_width(WINDOW);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign busy_o   = busy_q;
    assign expire_o = busy_q & ~done_i & ~start_i & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && !done_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done_i || expire_o) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= LAST));

    assert_expire_closes_R2: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !busy_q);

endmodule

// File: rtl/busmon_route.sv
module busmon_route
    import busmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fault_ev_t tgt_ev_i,
    input  fault_ev_t to_ev_i,
    input  logic      stat_rd_i,
    output logic      core_err_o,
    output logic      fault_fetch_o,
    output logic      fault_ldst_o,
    output logic      stat_timeout_o,
    output logic      stat_tgterr_o
);
    logic core_err_q, ff_q, fl_q, st_to_q, st_te_q;
    logic hit_fetch, hit_ldst;

    assign hit_fetch = (to_ev_i.hit  && to_ev_i.kind  == ACC_FETCH) ||
                       (tgt_ev_i.hit && tgt_ev_i.kind == ACC_FETCH);
    assign hit_ldst  = (to_ev_i.hit  && to_ev_i.kind  == ACC_DATA) ||
                       (tgt_ev_i.hit && tgt_ev_i.kind == ACC_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            core_err_q <= 1'b0;
            ff_q       <= 1'b0;
            fl_q       <= 1'b0;
        end else begin
            core_err_q <= to_ev_i.hit;
            ff_q       <= hit_fetch;
            fl_q       <= hit_ldst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_to_q <= 1'b0;
            st_te_q <= 1'b0;
        end else if (to_ev_i.hit) begin
            st_to_q <= 1'b1;
            st_te_q <= 1'b0;
        end else if (tgt_ev_i.hit) begin
            st_to_q <= 1'b0;
            st_te_q <= 1'b1;
        end else if (stat_rd_i) begin
            st_to_q <= 1'b0;
            st_te_q <= 1'b0;
        end
    end

    assign core_err_o     = core_err_q;
    assign fault_fetch_o  = ff_q;
    assign fault_ldst_o   = fl_q;
    assign stat_timeout_o = st_to_q;
    assign stat_tgterr_o  = st_te_q;

    assert_no_dual_event_R3: assert property (@(posedge clk) disable iff (rst)
        !(tgt_ev_i.hit && to_ev_i.hit));

    assert_err_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        core_err_q |=> !core_err_q);

    assert_fault_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ff_q, fl_q}));

    assert_err_has_fault_R7: assert property (@(posedge clk) disable iff (rst)
        core_err_q |-> (ff_q || fl_q) && st_to_q);

    assert_status_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(st_to_q && st_te_q));

endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
    import busmon_pkg::*;
#(
    parameter int WINDOW = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_rd_i,
    input  logic bus_wr_i,
    input  logic bus_ext_i,
    input  logic bus_fetch_i,
    input  logic bus_ack_i,
    input  logic bus_err_i,
    input  logic stat_rd_i,
    output logic core_err_o,
    output logic fault_fetch_o,
    output logic fault_ldst_o,
    output logic stat_timeout_o,
    output logic stat_tgterr_o
);
    logic      start, resp, busy, expire;
    acc_kind_e kind_q;
    fault_ev_t tgt_ev, to_ev;

    // Only internal strobes open a tracked transfer (R4).
    assign start = (bus_rd_i | bus_wr_i) & ~bus_ext_i;
    assign resp  = bus_ack_i | bus_err_i;

    busmon_window #(.WINDOW(WINDOW)) i_window (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .done_i   (resp),
        .busy_o   (busy),
        .expire_o (expire)
    );

    // Source tag of the transfer in flight; a restart re-captures it (R5).
    always_ff @(posedge clk) begin
        if (rst)        kind_q <= ACC_DATA;
        else if (start) kind_q <= acc_kind_e'(bus_fetch_i);
    end

    always_comb begin
        tgt_ev.hit  = bus_err_i & (busy | start);
        tgt_ev.kind = start ? acc_kind_e'(bus_fetch_i) : kind_q;
        to_ev.hit   = expire;
        to_ev.kind  = kind_q;
    end

    busmon_route i_route (
        .clk            (clk),
        .rst            (rst),
        .tgt_ev_i       (tgt_ev),
        .to_ev_i        (to_ev),
        .stat_rd_i      (stat_rd_i),
        .core_err_o     (core_err_o),
        .fault_fetch_o  (fault_fetch_o),
        .fault_ldst_o   (fault_ldst_o),
        .stat_timeout_o (stat_timeout_o),
        .stat_tgterr_o  (stat_tgterr_o)
    );

    assert_ext_untracked_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_ext_i && !resp) |=> !busy);

    assert_stray_resp_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && resp) |=> !fault_fetch_o && !fault_ldst_o);

endmodule

// File: tb/test_bus_timeout_monitor.sv
`timescale 1ns/1ps
module test_bus_timeout_monitor;
    localparam int W = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd = 0, wr = 0, ext = 0, fetch = 0, ack = 0, err = 0, srd = 0;
    logic core_err, f_fetch, f_ldst, s_to, s_te;

    int vectors = 0;
    int fails   = 0;
    bit m_to = 0, m_te = 0;   // expected sticky status
    bit finished = 0;

    always #2.5 clk = ~clk;

    bus_timeout_monitor #(.WINDOW(W)) i_bus_timeout_monitor (
        .clk(clk), .rst(rst), .bus_rd_i(rd), .bus_wr_i(wr), .bus_ext_i(ext),
        .bus_fetch_i(fetch), .bus_ack_i(ack), .bus_err_i(err), .stat_rd_i(srd),
        .core_err_o(core_err), .fault_fetch_o(f_fetch), .fault_ldst_o(f_ldst),
        .stat_timeout_o(s_to), .stat_tgterr_o(s_te)
    );

    task automatic chk(input string req, input string sig, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%b exp=%b at %0t", req, sig, got, exp, $time);
        end
    endtask

    // k: response cycle (-1 none); s2: restart cycle (-1 none); rdc: status read cycle (-1 none)
    task automatic txn(input int k, input bit use_err, input bit is_ext, input bit tag,
                       input int s2, input bit tag2, input int rdc, input string req);
        int  st   = (s2 >= 0) ? s2 : 0;
        bit  kind = (s2 >= 0) ? tag2 : tag;
        bit  answered = !is_ext && s2 < 0 && k >= 0 && k <= W;
        bit  tmo  = !is_ext && !answered;
        bit  ehit = answered && use_err;
        int  toc  = st + W + 1;
        int  lim  = W + 4 + ((s2 > 0) ? s2 : 0);
        for (int j = 0; j <= lim; j++) begin
            bit ev;
            @(negedge clk);
            if (j > 0) begin
                ev = (tmo && j == toc) || (ehit && j == k + 1);
                chk({req, " R2 R3"}, "core_err", core_err, tmo && j == toc);
                chk({req, " R7"}, "fault_fetch", f_fetch, ev && ((tmo && j == toc) ? kind : tag));
                chk({req, " R7"}, "fault_ldst", f_ldst, ev && !((tmo && j == toc) ? kind : tag));
                chk({req, " R8 R9"}, "stat_timeout", s_to, m_to);
                chk({req, " R8 R9"}, "stat_tgterr", s_te, m_te);
            end
            rd    = (j == 0 || j == s2) && ((j == 0) ? tag : tag2);
            wr    = (j == 0 || j == s2) && !((j == 0) ? tag : tag2);
            fetch = (j == s2 && s2 >= 0) ? tag2 : tag;
            ext   = is_ext;
            ack   = (k >= 0 && j == k && !use_err);
            err   = (k >= 0 && j == k && use_err);
            srd   = (j == rdc);
            // requirement model of the status bits at the edge closing cycle j
            if (tmo && j == toc - 1)        begin m_to = 1; m_te = 0; end
            else if (ehit && j == k)        begin m_te = 1; m_to = 0; end
            else if (j == rdc)              begin m_to = 0; m_te = 0; end
        end
        @(negedge clk);
        {rd, wr, ext, ack, err, srd} = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "core_err", core_err, 0);
        chk("R1", "fault_fetch", f_fetch, 0);
        chk("R1", "fault_ldst", f_ldst, 0);
        chk("R1", "stat_timeout", s_to, 0);
        chk("R1", "stat_tgterr", s_te, 0);

        // R2 R3 R7: sweep response delay, kind and source tag
        for (int k = -1; k <= W + 2; k++)
            for (int e = 0; e < 2; e++)
                for (int t = 0; t < 2; t++)
                    txn(k, e[0], 0, t[0], -1, 0, -1, "sweep");

        // R4: external accesses are never tracked
        for (int k = -1; k <= 3; k++)
            for (int e = 0; e < 2; e++)
                txn(k, e[0], 1, k[0], -1, 0, -1, "ext R4");

        // R5: restart of the window with a new tag
        txn(-1, 0, 0, 0, 1, 1, -1, "restart R5");
        txn(-1, 0, 0, 1, 5, 0, -1, "restart R5");
        txn(-1, 0, 0, 0, W, 1, -1, "restart R5");

        // R6: stray responses with nothing open
        for (int e = 0; e < 2; e++) begin
            @(negedge clk);
            ack = !e[0]; err = e[0];
            @(negedge clk);
            ack = 0; err = 0;
            @(negedge clk);
            chk("R6", "fault_fetch", f_fetch, 0);
            chk("R6", "fault_ldst", f_ldst, 0);
            chk("R6", "core_err", core_err, 0);
            chk("R6", "stat_timeout", s_to, m_to);
            chk("R6", "stat_tgterr", s_te, m_te);
        end

        // R9: read collides with a set event, then a later read clears
        txn(2, 1, 0, 1, -1, 0, 2, "collide err R9");
        txn(-1, 0, 0, 0, -1, 0, W, "collide tmo R9");
        txn(3, 1, 0, 0, -1, 0, 5, "late read R9");
        txn(-1, 0, 0, 1, -1, 0, W + 2, "late read R9");
        // R8: timeout followed by target error, last one wins
        txn(-1, 0, 0, 1, -1, 0, -1, "last wins R8");
        txn(0, 1, 0, 0, -1, 0, -1, "last wins R8");

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule